// File: doc/BRIEF.md
# Integer Status Flag Generator

This unit sits beside a 64-bit integer datapath and turns the operands and result of a finished operation into status bits: a carry bit and an overflow bit for the full 64-bit word, the same two bits for the low 32-bit half, a sticky summary-overflow bit, and a 4-bit condition field. The arithmetic itself is done elsewhere. The unit only sees the operand values, the result and the per-instruction enables.

The operand list is built from operand A, optionally bit-inverted for subtract-style operations, then operand B when present, then an immediate when valid. Carry is taken as "some operand, compared unsigned, is larger than the result". Overflow looks at the sign bits of the first two operands in the list and of the result. An instruction that produces its own carry bits can supply them, and they replace the computed values. All state updates when the instruction-complete strobe is high.

Top module: `int_flag_unit`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, every flag output and the condition field read 0.
- R2: State changes only on a clock edge where `done_i` is high. With `done_i` low, all outputs hold their values regardless of the other inputs.
- R3: With `carry_en_i` high and `ca_own_i` low, `ca_o` becomes 1 exactly when some present operand (A, B if `opb_vld_i`, immediate if `imm_vld_i`), compared as unsigned 64-bit numbers, is greater than `res_i`.
- R4: With `carry_en_i` high and `ca32_own_i` low, `ca32_o` applies the R3 rule to bits 31:0 of each present operand and of the result.
- R5: When `inv_a_i` is high, every carry and overflow rule uses the bitwise inverse of `opa_i` in place of `opa_i`.
- R6: With `carry_en_i` high, `ca_own_i` high makes `ca_o` take `ca_own_val_i` instead of the computed value. `ca32_own_i` and `ca32_own_val_i` do the same, independently, for `ca32_o`.
- R7: With `carry_en_i` low, `ca_o` and `ca32_o` keep their values.
- R8: With `ov_en_i` and `ov_vld_i` both high and at least two operands present, `ov_o` is 1 when the first two operands share bit 63 and the result's bit 63 differs from it. `ov32_o` uses the same rule on bit 31. The second operand is B when `opb_vld_i` is high, otherwise the immediate.
- R9: If `ov_en_i` or `ov_vld_i` is low, or fewer than two operands are present, `ov_o`, `ov32_o` and `so_o` keep their values.
- R10: An overflow update sets `so_o` to its old value OR the new `ov_o`. Once set, `so_o` only returns to 0 through reset.
- R11: With `rec_en_i` high, `cr0_o` becomes {bit 3 negative, bit 2 positive, bit 1 zero, bit 0 summary overflow}. The sign is judged from `res_i` as a signed 64-bit value, and bit 0 is the summary overflow including this instruction's overflow. With `rec_en_i` low, `cr0_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | Instruction-complete strobe; commits the new flags |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second register operand |
| opb_vld_i | input | 1 | Second register operand is present |
| inv_a_i | input | 1 | Use the bitwise inverse of the first operand |
| imm_i | input | 64 | Immediate operand |
| imm_vld_i | input | 1 | Immediate is present and joins the operand list |
| res_i | input | 64 | Result of the operation |
| carry_en_i | input | 1 | Carry bits are updated by this instruction |
| ca_own_i | input | 1 | Instruction supplies its own 64-bit carry |
| ca_own_val_i | input | 1 | Supplied 64-bit carry value |
| ca32_own_i | input | 1 | Instruction supplies its own 32-bit carry |
| ca32_own_val_i | input | 1 | Supplied 32-bit carry value |
| ov_en_i | input | 1 | Overflow update requested |
| ov_vld_i | input | 1 | Overflow request is valid |
| rec_en_i | input | 1 | Update the condition field |
| ca_o | output | 1 | 64-bit carry |
| ca32_o | output | 1 | 32-bit carry |
| ov_o | output | 1 | 64-bit overflow |
| ov32_o | output | 1 | 32-bit overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The bench builds the unit with its default widths: a 64-bit word and a 32-bit low half. With these values, hand-picked operands can land where the two halves disagree. One is a carry out of bit 31 with none out of bit 63, another an overflow at bit 31 alone. The bench can also show inversion of A turning an overflow on at bit 63 and off at bit 31. The same widths let it place an ignored B operand or a lone operand so that wrongly using them would flip the 64-bit carry or overflow.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    // Number of operand slots: A, B, immediate
    localparam int unsigned NOPS = 3;
    localparam int unsigned SLOT_A   = 0;
    localparam int unsigned SLOT_B   = 1;
    localparam int unsigned SLOT_IMM = 2;

    // Condition field bit positions
    localparam int unsigned CR_NEG  = 3;
    localparam int unsigned CR_POS  = 2;
    localparam int unsigned CR_ZERO = 1;
    localparam int unsigned CR_SO   = 0;

    typedef struct packed {
        logic       ca;
        logic       ca32;
        logic       ov;
        logic       ov32;
        logic       so;
        logic [3:0] cr0;
    } ifu_flags_t;

endpackage

// File: rtl/ifu_opnd_sel.sv
// Builds the operand list and picks the pair used by the overflow rule.
module ifu_opnd_sel
    import ifu_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0]             opa_i,
    input  logic [DW-1:0]             opb_i,
    input  logic                      opb_vld_i,
    input  logic                      inv_a_i,
    input  logic [DW-1:0]             imm_i,
    input  logic                      imm_vld_i,
    output logic [NOPS-1:0][DW-1:0]   ops_o,
    output logic [NOPS-1:0]           ops_vld_o,
    output logic [DW-1:0]             ovx_o,
    output logic [DW-1:0]             ovy_o,
    output logic                      ov_pair_ok_o
);

    logic [DW-1:0] a_eff;

    always_comb begin
        a_eff = inv_a_i ? ~opa_i : opa_i;

        ops_o[SLOT_A]       = a_eff;
        ops_o[SLOT_B]       = opb_i;
        ops_o[SLOT_IMM]     = imm_i;
        ops_vld_o[SLOT_A]   = 1'b1;
        ops_vld_o[SLOT_B]   = opb_vld_i;
        ops_vld_o[SLOT_IMM] = imm_vld_i;

        // First two operands of the list: A, then B if present, else imm
        ovx_o        = a_eff;
        ovy_o        = opb_vld_i ? opb_i : imm_i;
        ov_pair_ok_o = opb_vld_i | imm_vld_i;
    end

endmodule

// File: rtl/ifu_carry_cmp.sv
// Carry = some valid operand is unsigned-greater than the result.
module ifu_carry_cmp #(
    parameter int unsigned W = 64,
    parameter int unsigned N = 3
) (
    input  logic [N-1:0][W-1:0] ops_i,
    input  logic [N-1:0]        vld_i,
    input  logic [W-1:0]        res_i,
    output logic                carry_o
);

    logic [N-1:0] gt;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign gt[g] = vld_i[g] && (ops_i[g] > res_i);
    end

    assign carry_o = |gt;

endmodule

// File: rtl/ifu_ovf_det.sv
// Signed overflow from the sign bits of two operands and the result.
module ifu_ovf_det #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] r_i,
    output logic         ov_o
);

    localparam int unsigned SB = W - 1;

    logic same_sign;

    always_comb begin
        same_sign = (x_i[SB] == y_i[SB]);
        ov_o      = same_sign && (r_i[SB] != x_i[SB]);
    end

endmodule

// File: rtl/ifu_cr_gen.sv
// Condition nibble from a signed result and the updated summary bit.
module ifu_cr_gen
    import ifu_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] res_i,
    input  logic          so_i,
    output logic [3:0]    cr_o
);

    logic neg;
    logic zero;

    always_comb begin
        neg           = res_i[DW-1];
        zero          = (res_i == '0);
        cr_o          = '0;
        cr_o[CR_NEG]  = neg;
        cr_o[CR_POS]  = !neg && !zero;
        cr_o[CR_ZERO] = zero;
        cr_o[CR_SO]   = so_i;
    end

endmodule

// File: rtl/int_flag_unit.sv
module int_flag_unit
    import ifu_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [63:0]   opa_i,
    input  logic [63:0]   opb_i,
    input  logic          opb_vld_i,
    input  logic          inv_a_i,
    input  logic [63:0]   imm_i,
    input  logic          imm_vld_i,
    input  logic [63:0]   res_i,
    input  logic          carry_en_i,
    input  logic          ca_own_i,
    input  logic          ca_own_val_i,
    input  logic          ca32_own_i,
    input  logic          ca32_own_val_i,
    input  logic          ov_en_i,
    input  logic          ov_vld_i,
    input  logic          rec_en_i,
    output logic          ca_o,
    output logic          ca32_o,
    output logic          ov_o,
    output logic          ov32_o,
    output logic          so_o,
    output logic [3:0]    cr0_o
);

    // ---------------------------------------------------------------
    // Operand list
    // ---------------------------------------------------------------
    logic [NOPS-1:0][DW-1:0] ops;
    logic [NOPS-1:0]         ops_vld;
    logic [DW-1:0]           ovx;
    logic [DW-1:0]           ovy;
    logic                    ov_pair_ok;

    ifu_opnd_sel #(.DW(DW)) u_sel (
        .opa_i        (opa_i[DW-1:0]),
        .opb_i        (opb_i[DW-1:0]),
        .opb_vld_i    (opb_vld_i),
        .inv_a_i      (inv_a_i),
        .imm_i        (imm_i[DW-1:0]),
        .imm_vld_i    (imm_vld_i),
        .ops_o        (ops),
        .ops_vld_o    (ops_vld),
        .ovx_o        (ovx),
        .ovy_o        (ovy),
        .ov_pair_ok_o (ov_pair_ok)
    );

    // Low-half views of each operand slot
    logic [NOPS-1:0][HW-1:0] ops_lo;
    for (genvar s = 0; s < NOPS; s++) begin : g_lo
        assign ops_lo[s] = ops[s][HW-1:0];
    end

    // ---------------------------------------------------------------
    // Carry, full word and low half
    // ---------------------------------------------------------------
    logic ca_calc;
    logic ca32_calc;

    ifu_carry_cmp #(.W(DW), .N(NOPS)) u_ca_full (
        .ops_i   (ops),
        .vld_i   (ops_vld),
        .res_i   (res_i[DW-1:0]),
        .carry_o (ca_calc)
    );

    ifu_carry_cmp #(.W(HW), .N(NOPS)) u_ca_half (
        .ops_i   (ops_lo),
        .vld_i   (ops_vld),
        .res_i   (res_i[HW-1:0]),
        .carry_o (ca32_calc)
    );

    // ---------------------------------------------------------------
    // Overflow, full word and low half
    // ---------------------------------------------------------------
    logic ov_calc;
    logic ov32_calc;

    ifu_ovf_det #(.W(DW)) u_ov_full (
        .x_i  (ovx),
        .y_i  (ovy),
        .r_i  (res_i[DW-1:0]),
        .ov_o (ov_calc)
    );

    ifu_ovf_det #(.W(HW)) u_ov_half (
        .x_i  (ovx[HW-1:0]),
        .y_i  (ovy[HW-1:0]),
        .r_i  (res_i[HW-1:0]),
        .ov_o (ov32_calc)
    );

    // ---------------------------------------------------------------
    // State: next-value computation and register
    // ---------------------------------------------------------------
    ifu_flags_t flags_d;
    ifu_flags_t flags_q;
    logic       ov_go;
    logic       so_upd;
    logic [3:0] cr_calc;

    assign ov_go  = ov_en_i && ov_vld_i && ov_pair_ok;
    assign so_upd = flags_q.so | (ov_go & ov_calc);

    ifu_cr_gen #(.DW(DW)) u_cr (
        .res_i (res_i[DW-1:0]),
        .so_i  (so_upd),
        .cr_o  (cr_calc)
    );

    always_comb begin
        flags_d = flags_q;
        if (carry_en_i) begin
            flags_d.ca   = ca_own_i   ? ca_own_val_i   : ca_calc;
            flags_d.ca32 = ca32_own_i ? ca32_own_val_i : ca32_calc;
        end
        if (ov_go) begin
            flags_d.ov   = ov_calc;
            flags_d.ov32 = ov32_calc;
        end
        flags_d.so = so_upd;
        if (rec_en_i) begin
            flags_d.cr0 = cr_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (done_i) begin
            flags_q <= flags_d;
        end
    end

    assign ca_o   = flags_q.ca;
    assign ca32_o = flags_q.ca32;
    assign ov_o   = flags_q.ov;
    assign ov32_o = flags_q.ov32;
    assign so_o   = flags_q.so;
    assign cr0_o  = flags_q.cr0;

endmodule

// File: rtl/ifu_flag_chk.sv
module ifu_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done_i,
    input logic       carry_en_i,
    input logic       ov_en_i,
    input logic       ov_vld_i,
    input logic       rec_en_i,
    input logic       ca_o,
    input logic       ca32_o,
    input logic       ov_o,
    input logic       ov32_o,
    input logic       so_o,
    input logic [3:0] cr0_o
);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}));

    assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !carry_en_i) |=> $stable({ca_o, ca32_o}));

    assert_ov_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !(ov_en_i && ov_vld_i)) |=> $stable({ov_o, ov32_o, so_o}));

    assert_so_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        so_o |=> so_o);

    assert_ov_sets_so_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ov_en_i && ov_vld_i) |=> (!ov_o || so_o));

    assert_cr_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rec_en_i) |=> (cr0_o[0] == so_o) && ($countones(cr0_o[3:1]) == 1));

endmodule

bind int_flag_unit ifu_flag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done_i),
    .carry_en_i (carry_en_i),
    .ov_en_i    (ov_en_i),
    .ov_vld_i   (ov_vld_i),
    .rec_en_i   (rec_en_i),
    .ca_o       (ca_o),
    .ca32_o     (ca32_o),
    .ov_o       (ov_o),
    .ov32_o     (ov32_o),
    .so_o       (so_o),
    .cr0_o      (cr0_o)
);

// File: tb/int_flag_unit_tb.sv
`timescale 1ns/1ps
module int_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [63:0] opa_i = '0, opb_i = '0, imm_i = '0, res_i = '0;
    logic        opb_vld_i = 1'b0, inv_a_i = 1'b0, imm_vld_i = 1'b0;
    logic        carry_en_i = 1'b0, ca_own_i = 1'b0, ca_own_val_i = 1'b0;
    logic        ca32_own_i = 1'b0, ca32_own_val_i = 1'b0;
    logic        ov_en_i = 1'b0, ov_vld_i = 1'b0, rec_en_i = 1'b0;
    logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
    logic [3:0]  cr0_o;

    always #2 clk = ~clk;

    int_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i),
        .opa_i(opa_i), .opb_i(opb_i), .opb_vld_i(opb_vld_i), .inv_a_i(inv_a_i),
        .imm_i(imm_i), .imm_vld_i(imm_vld_i), .res_i(res_i),
        .carry_en_i(carry_en_i), .ca_own_i(ca_own_i), .ca_own_val_i(ca_own_val_i),
        .ca32_own_i(ca32_own_i), .ca32_own_val_i(ca32_own_val_i),
        .ov_en_i(ov_en_i), .ov_vld_i(ov_vld_i), .rec_en_i(rec_en_i),
        .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o),
        .so_o(so_o), .cr0_o(cr0_o)
    );

    // ctl bits, MSB first: inv bv iv cen cown cownv c32own c32ownv oen ovld rec
    // exp bits, MSB first: ca ca32 ov ov32 so cr0[3:0]
    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] imm;
        logic [63:0] res;
        logic [10:0] ctl;
        logic [8:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{64'h1, 64'h2, 64'h0, 64'h3,
          11'b0_1_0_1_0_0_0_0_1_1_1, 9'b0_0_0_0_0_0100},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 64'h0,
          11'b0_1_0_1_0_0_0_0_1_1_1, 9'b1_1_0_0_0_0010},
        '{64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 64'h1_0000_0000,
          11'b0_1_0_1_0_0_0_0_1_1_1, 9'b0_1_0_0_0_0100},
        '{64'h7FFF_FFFF, 64'h1, 64'h0, 64'h8000_0000,
          11'b0_1_0_1_0_0_0_0_1_1_1, 9'b0_0_0_1_0_0100},
        '{64'h0, 64'h5, 64'h0, 64'h0,
          11'b1_1_0_0_0_0_0_0_0_0_0, 9'b0_0_0_1_0_0100},
        '{64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h7FFF_FFFF_FFFF_FFFF,
          11'b1_1_0_1_0_0_0_0_1_1_1, 9'b1_0_1_0_1_0101},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 64'h0,
          11'b0_1_0_1_1_0_0_0_0_0_0, 9'b0_1_1_0_1_0101},
        '{64'h1, 64'h2, 64'h0, 64'h3,
          11'b0_1_0_1_0_0_1_1_1_1_1, 9'b0_1_0_0_1_0101},
        '{64'h1, 64'h1, 64'h10, 64'h5,
          11'b0_1_1_1_0_0_0_0_0_0_1, 9'b1_1_0_0_1_0101},
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000,
          11'b0_0_1_1_0_0_0_0_1_1_1, 9'b0_1_1_0_1_1001},
        '{64'h1, 64'h2, 64'h0, 64'h3,
          11'b0_1_0_0_0_0_0_0_1_0_0, 9'b0_1_1_0_1_1001},
        '{64'h1, 64'hFFFF, 64'h0, 64'h3,
          11'b0_0_0_1_0_0_0_0_1_1_1, 9'b0_0_1_0_1_0101}
    };

    function automatic string vec_req(int i);
        case (i)
            0:  return "R3 R8 R11 plain add";
            1:  return "R3 R4 R11 wrap to zero";
            2:  return "R4 carry from low half only";
            3:  return "R8 overflow at bit 31 only";
            4:  return "R5 R7 R9 R11 disabled updates hold";
            5:  return "R5 R8 R10 R11 inverted A overflow";
            6:  return "R6 own CA replaces computed";
            7:  return "R6 R10 own CA32 replaces computed";
            8:  return "R3 R4 immediate as extra operand";
            9:  return "R8 immediate as second operand";
            10: return "R9 overflow valid low holds";
            default: return "R9 R3 single operand";
        endcase
    endfunction

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = {ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic strobe);
        opa_i          = v.a;
        opb_i          = v.b;
        imm_i          = v.imm;
        res_i          = v.res;
        inv_a_i        = v.ctl[10];
        opb_vld_i      = v.ctl[9];
        imm_vld_i      = v.ctl[8];
        carry_en_i     = v.ctl[7];
        ca_own_i       = v.ctl[6];
        ca_own_val_i   = v.ctl[5];
        ca32_own_i     = v.ctl[4];
        ca32_own_val_i = v.ctl[3];
        ov_en_i        = v.ctl[2];
        ov_vld_i       = v.ctl[1];
        rec_en_i       = v.ctl[0];
        done_i         = strobe;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        vec_t ov_only;
        vec_t quiet_ov;
        repeat (3) @(negedge clk);
        check("R1 during reset", 9'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 9'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            done_i = 1'b0;
            check(vec_req(i), VECS[i].exp);
        end

        // R2: a vector that would change everything, strobe low
        drive(VECS[1], 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R2 no strobe holds", 9'b0_0_1_0_1_0101);

        // R1 / R10: reset clears the sticky bit
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R10 reset clears sticky", 9'b0);

        // R10: set SO without record, then a non-overflowing update
        ov_only  = VECS[5];
        ov_only.ctl = 11'b1_1_0_0_0_0_0_0_1_1_0;
        drive(ov_only, 1'b1);
        @(negedge clk);
        done_i = 1'b0;
        check("R10 overflow sets so", 9'b0_0_1_0_1_0000);
        quiet_ov = VECS[0];
        quiet_ov.ctl = 11'b0_1_0_0_0_0_0_0_1_1_0;
        drive(quiet_ov, 1'b1);
        @(negedge clk);
        done_i = 1'b0;
        check("R10 so stays after clean op", 9'b0_0_0_0_1_0000);

        finish_run();
    end

endmodule